// File: doc/BRIEF.md
# Low-Power State Entry Sequencer

This block steps a device function into a deep low-power state when configuration software writes the deep-sleep code into the function's power-state field. The entry runs as a fixed sequence. It first closes a gate that stops the request scheduler from starting new bus transactions. It then waits until every transaction already in flight has been acknowledged. Next it pulses clears for both the memory-space and I/O-space decode enables of the command register. Only after that does it ask the serial link to move to its L1 low-power state, and it settles once the link acknowledges.

While the function sleeps, receive data that had not yet reached host memory stays on chip. The block records that such data exists. When software writes the full-power code, the block issues a one-cycle flush pulse so the data is discarded. In the same step it drops the link low-power request and reopens the scheduler gate. If wake signalling or power-management event signalling is enabled when entry begins, the block also holds a request for the PHY to renegotiate down to a lower line speed until exit.

The outstanding-transaction count is kept inside the block. It is driven by one-cycle issue and completion strobes.

Top module: `lps_entry_seq`

## Requirements
- R1: After reset every output is low: `sched_gate`, both decode clears, `link_l1_req`, `phy_downshift_req`, `rx_flush`, `rx_held` and `in_low_power`.
- R2: When idle at full power, a write of power-state code 2'b11 (deep low-power) raises `sched_gate` in the cycle after the write. The gate stays high through the whole entry and the low-power state.
- R3: `mem_en_clr` and `io_en_clr` pulse together for exactly one cycle per entry. The pulse comes only when the outstanding count is zero. It comes no earlier than the second cycle after the deep-state write.
- R4: `link_l1_req` rises in the cycle after the decode-clear pulse. It stays high until exit.
- R5: The outstanding count rises by one for each `req_issue`, falls by one for each `req_done`, and is unchanged when both strobe in the same cycle. The drain ends in the cycle the count reaches zero.
- R6: `phy_downshift_req` rises together with the gate when `wake_en` or `pme_en` is high in the cycle of the deep-state write. Later changes to those inputs have no effect. It clears on exit.
- R7: `link_l1_ack` is honoured only while `link_l1_req` is high. It moves the block into the low-power state, which is shown by `in_low_power`.
- R8: A write of code 2'b00 (full power) during the low-power state clears `sched_gate`, `link_l1_req`, `phy_downshift_req` and `in_low_power` in the next cycle. `rx_flush` is high for that one cycle only if receive data was held. The block is back at full power the cycle after.
- R9: `rx_pending` seen while the block is between entry and exit sets `rx_held`. `rx_flush` never asserts during entry. `rx_held` clears after the flush cycle.
- R10: Before the low-power state is reached, writes of any code other than 2'b11 at full power are ignored, and any write during the entry steps is ignored.
- R11: A repeated write of code 2'b11 during the low-power state is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pm_wr_en | input | 1 | Power-state field write strobe |
| pm_wr_code | input | 2 | Power-state code written (2'b00 full, 2'b11 deep) |
| req_issue | input | 1 | One bus transaction issued this cycle |
| req_done | input | 1 | One transaction acknowledged this cycle |
| link_l1_ack | input | 1 | Link layer reports entry to L1 |
| wake_en | input | 1 | Wake signalling enabled |
| pme_en | input | 1 | Power-management event signalling enabled |
| rx_pending | input | 1 | Receive data held on chip, not yet in host memory |
| sched_gate | output | 1 | Blocks the scheduler from starting new transactions |
| mem_en_clr | output | 1 | One-cycle clear of the memory decode enable |
| io_en_clr | output | 1 | One-cycle clear of the I/O decode enable |
| link_l1_req | output | 1 | Request for the serial link to enter L1 |
| phy_downshift_req | output | 1 | Request for the PHY to renegotiate to a lower speed |
| rx_flush | output | 1 | One-cycle discard of held receive data on exit |
| rx_held | output | 1 | Receive data is being held across the low-power state |
| in_low_power | output | 1 | Low-power state reached |

## Verification
The bench builds the block with a 3-bit outstanding counter. This lets a sweep cover every drain depth from zero to the counter's full value of seven. The sweep crosses each depth with all four wake/event enable combinations and with receive data held or absent. For each case, the exact cycle of the decode-clear pulse, the link request and the arrival in low power is computed arithmetically from the depth. The preload mixes same-cycle issue/completion pairs, so any miscounted pair shifts the drain end and is caught.

// File: rtl/lps_pkg.sv
// Shared codes and the sequencer state type.
// Assumes a 2-bit power-state field; only the two extreme codes carry meaning.
package lps_pkg;
    localparam int PS_W = 2;
    localparam logic [PS_W-1:0] PS_FULL = 2'b00;
    localparam logic [PS_W-1:0] PS_DEEP = 2'b11;

    typedef enum logic [2:0] {
        ST_ACTIVE   = 3'd0,
        ST_GATE     = 3'd1,
        ST_DRAIN    = 3'd2,
        ST_LINK_REQ = 3'd3,
        ST_LOWPWR   = 3'd4,
        ST_EXIT     = 3'd5
    } seq_state_e;
endpackage

// File: rtl/lps_cmd_decode.sv
// Turns a power-state field write into enter and exit requests.
// Assumes the write strobe is one cycle wide; codes other than full/deep decode to nothing.
module lps_cmd_decode
    import lps_pkg::*;
(
    input  logic            pm_wr_en,
    input  logic [PS_W-1:0] pm_wr_code,
    output logic            enter_req,
    output logic            exit_req
);
    // Match the written code against the two meaningful values.
    always_comb begin
        enter_req = pm_wr_en && (pm_wr_code == PS_DEEP);
        exit_req  = pm_wr_en && (pm_wr_code == PS_FULL);
    end
endmodule

// File: rtl/lps_pend_ctr.sv
// Counts bus transactions issued but not yet acknowledged.
// Assumes the count never exceeds 2**CNT_W-1 and that no completion arrives at zero.
module lps_pend_ctr #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] count,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // Next count: a same-cycle issue and completion cancel out.
    always_comb begin
        case ({inc, dec})
            2'b10:   cnt_d = cnt_q + 1'b1;
            2'b01:   cnt_d = cnt_q - 1'b1;
            default: cnt_d = cnt_q;
        endcase
    end

    // Count register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;
    assign zero  = (cnt_q == '0);
endmodule

// File: rtl/lps_seq_fsm.sv
// Ordered entry/exit controller: gate, drain, clear decode, request L1, sleep, exit.
// Assumes 'drained' reflects the registered outstanding count and that the link
// acknowledge is meaningful only after the request is raised.
module lps_seq_fsm
    import lps_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enter_req,
    input  logic exit_req,
    input  logic drained,
    input  logic link_ack,
    input  logic wake_any,
    input  logic rx_pending,
    output logic sched_gate,
    output logic decode_clr,
    output logic link_req,
    output logic downshift,
    output logic rx_flush,
    output logic rx_held,
    output logic in_lowpwr
);
    seq_state_e state_q, state_d;
    logic decode_clr_q, link_req_q, downshift_q, rx_held_q;
    logic entering, leaving, sleeping;

    // Next-state selection for the ordered sequence.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_ACTIVE:   if (enter_req) state_d = ST_GATE;
            ST_GATE:     state_d = ST_DRAIN;
            ST_DRAIN:    if (drained) state_d = ST_LINK_REQ;
            ST_LINK_REQ: if (link_req_q && link_ack) state_d = ST_LOWPWR;
            ST_LOWPWR:   if (exit_req) state_d = ST_EXIT;
            ST_EXIT:     state_d = ST_ACTIVE;
            default:     state_d = ST_ACTIVE;
        endcase
    end

    // Transition qualifiers shared by the output registers.
    always_comb begin
        entering = (state_q == ST_ACTIVE) && enter_req;
        leaving  = (state_q == ST_LOWPWR) && exit_req;
        sleeping = (state_q != ST_ACTIVE) && (state_q != ST_EXIT);
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_ACTIVE;
        else        state_q <= state_d;
    end

    // One-cycle decode-clear pulse on the drain-complete transition.
    always_ff @(posedge clk) begin
        if (!rst_n) decode_clr_q <= 1'b0;
        else        decode_clr_q <= (state_q == ST_DRAIN) && drained;
    end

    // Link low-power request: raised after the decode clear, dropped on exit.
    always_ff @(posedge clk) begin
        if (!rst_n)                       link_req_q <= 1'b0;
        else if (leaving)                 link_req_q <= 1'b0;
        else if (state_q == ST_LINK_REQ)  link_req_q <= 1'b1;
    end

    // PHY downshift request: enables sampled once at entry, held until exit.
    always_ff @(posedge clk) begin
        if (!rst_n)        downshift_q <= 1'b0;
        else if (entering) downshift_q <= wake_any;
        else if (leaving)  downshift_q <= 1'b0;
    end

    // Held-receive flag: set while asleep, released after the flush cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                          rx_held_q <= 1'b0;
        else if (state_q == ST_EXIT)         rx_held_q <= 1'b0;
        else if (sleeping && rx_pending)     rx_held_q <= 1'b1;
    end

    // Moore outputs decoded from state and the registers above.
    always_comb begin
        sched_gate = sleeping;
        decode_clr = decode_clr_q;
        link_req   = link_req_q;
        downshift  = downshift_q;
        rx_held    = rx_held_q;
        rx_flush   = (state_q == ST_EXIT) && rx_held_q;
        in_lowpwr  = (state_q == ST_LOWPWR);
    end
endmodule

// File: rtl/lps_entry_seq.sv
// Top of the low-power entry sequencer: decodes power-state writes, tracks
// outstanding transactions and runs the ordered entry/exit controller.
// Assumes one power-state write per cycle at most and well-formed issue/done strobes.
module lps_entry_seq
    import lps_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pm_wr_en,
    input  logic [PS_W-1:0] pm_wr_code,
    input  logic            req_issue,
    input  logic            req_done,
    input  logic            link_l1_ack,
    input  logic            wake_en,
    input  logic            pme_en,
    input  logic            rx_pending,
    output logic            sched_gate,
    output logic            mem_en_clr,
    output logic            io_en_clr,
    output logic            link_l1_req,
    output logic            phy_downshift_req,
    output logic            rx_flush,
    output logic            rx_held,
    output logic            in_low_power
);
    logic             enter_req, exit_req;
    logic [CNT_W-1:0] pend_cnt;
    logic             pend_zero;
    logic             decode_clr;
    logic             wake_any;

    // Either wake path asks for the lower PHY speed.
    assign wake_any = wake_en | pme_en;

    lps_cmd_decode u_dec (
        .pm_wr_en   (pm_wr_en),
        .pm_wr_code (pm_wr_code),
        .enter_req  (enter_req),
        .exit_req   (exit_req)
    );

    lps_pend_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (req_issue),
        .dec   (req_done),
        .count (pend_cnt),
        .zero  (pend_zero)
    );

    lps_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .enter_req  (enter_req),
        .exit_req   (exit_req),
        .drained    (pend_zero),
        .link_ack   (link_l1_ack),
        .wake_any   (wake_any),
        .rx_pending (rx_pending),
        .sched_gate (sched_gate),
        .decode_clr (decode_clr),
        .link_req   (link_l1_req),
        .downshift  (phy_downshift_req),
        .rx_flush   (rx_flush),
        .rx_held    (rx_held),
        .in_lowpwr  (in_low_power)
    );

    // Both decode enables are cleared by the same pulse.
    assign mem_en_clr = decode_clr;
    assign io_en_clr  = decode_clr;
endmodule

// File: rtl/lps_entry_seq_chk.sv
// Temporal checks for the entry sequencer, bound to every instance of the top.
module lps_entry_seq_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_issue,
    input logic             req_done,
    input logic [CNT_W-1:0] pend_cnt,
    input logic             sched_gate,
    input logic             mem_en_clr,
    input logic             io_en_clr,
    input logic             link_l1_req,
    input logic             phy_downshift_req,
    input logic             rx_flush,
    input logic             in_low_power
);
    p_clear_drained_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en_clr |-> (pend_cnt == '0) && sched_gate);
    p_clear_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en_clr || io_en_clr) |-> (mem_en_clr && io_en_clr));
    p_clear_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en_clr |=> !mem_en_clr);
    p_req_after_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_l1_req) |-> $past(mem_en_clr));
    p_count_inc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_issue && !req_done) |=> pend_cnt == $past(pend_cnt) + 1'b1);
    p_count_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_issue && req_done) |=> pend_cnt == $past(pend_cnt) - 1'b1);
    p_count_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_issue == req_done) |=> $stable(pend_cnt));
    p_downshift_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        phy_downshift_req |-> sched_gate);
    p_lowpwr_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_low_power |-> link_l1_req && sched_gate);
    p_flush_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_flush |=> !rx_flush);
    p_flush_open_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_flush |-> !sched_gate && !link_l1_req && !in_low_power);
endmodule

bind lps_entry_seq lps_entry_seq_chk #(.CNT_W(CNT_W)) u_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .req_issue         (req_issue),
    .req_done          (req_done),
    .pend_cnt          (pend_cnt),
    .sched_gate        (sched_gate),
    .mem_en_clr        (mem_en_clr),
    .io_en_clr         (io_en_clr),
    .link_l1_req       (link_l1_req),
    .phy_downshift_req (phy_downshift_req),
    .rx_flush          (rx_flush),
    .in_low_power      (in_low_power)
);

// File: tb/tb_lps_entry_seq.sv
`timescale 1ns/100ps
module tb_lps_entry_seq;
    localparam int CW = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pm_wr_en = 1'b0;
    logic [1:0] pm_wr_code = 2'b00;
    logic       req_issue = 1'b0, req_done = 1'b0, link_l1_ack = 1'b0;
    logic       wake_en = 1'b0, pme_en = 1'b0, rx_pending = 1'b0;
    logic       sched_gate, mem_en_clr, io_en_clr, link_l1_req;
    logic       phy_downshift_req, rx_flush, rx_held, in_low_power;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    lps_entry_seq #(.CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .pm_wr_en(pm_wr_en), .pm_wr_code(pm_wr_code),
        .req_issue(req_issue), .req_done(req_done), .link_l1_ack(link_l1_ack),
        .wake_en(wake_en), .pme_en(pme_en), .rx_pending(rx_pending),
        .sched_gate(sched_gate), .mem_en_clr(mem_en_clr), .io_en_clr(io_en_clr),
        .link_l1_req(link_l1_req), .phy_downshift_req(phy_downshift_req),
        .rx_flush(rx_flush), .rx_held(rx_held), .in_low_power(in_low_power)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input logic act, input logic exp, input string what);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at %0t", what, act, exp, $time);
        end
    endtask

    task automatic run(input int n, input int w, input int r);
        int  k;
        int  rem;
        logic ds;
        // Preload n outstanding requests; odd steps add a same-cycle pair (R5).
        for (int i = 0; i < n; i++) begin
            req_issue = 1'b1; step(); req_issue = 1'b0;
            if (i % 2 == 1) begin
                req_issue = 1'b1; req_done = 1'b1; step();
                req_issue = 1'b0; req_done = 1'b0;
            end
        end
        // Non-deep codes at full power must not start entry (R10).
        for (int c = 0; c < 3; c++) begin
            pm_wr_en = 1'b1; pm_wr_code = c[1:0]; step(); pm_wr_en = 1'b0;
            chk(sched_gate, 1'b0, "R10 non-deep write at full power");
        end
        link_l1_ack = 1'b1;
        wake_en = w[0]; pme_en = w[1];
        pm_wr_en = 1'b1; pm_wr_code = 2'b11; step();
        pm_wr_en = 1'b0; wake_en = ~w[0]; pme_en = ~w[1];
        ds = (w != 0);
        chk(sched_gate, 1'b1, "R2 gate after deep write");
        chk(phy_downshift_req, ds, "R6 downshift at entry");
        chk(mem_en_clr, 1'b0, "R3 no clear in gate cycle");
        k   = (n + 1 > 2) ? n + 1 : 2;
        rem = n;
        for (int j = 1; j <= k + 3; j++) begin
            req_done   = (rem > 0);
            if (rem > 0) rem--;
            rx_pending = (j == 1) && (r != 0);
            if (j == 1) begin pm_wr_en = 1'b1; pm_wr_code = 2'b00; end
            step();
            req_done = 1'b0; rx_pending = 1'b0; pm_wr_en = 1'b0;
            chk(mem_en_clr, j == k, "R3/R5 memory clear timing");
            chk(io_en_clr, j == k, "R3 io clear timing");
            chk(link_l1_req, j >= k + 1, "R4 link request timing");
            chk(in_low_power, j >= k + 2, "R7 low-power arrival");
            chk(sched_gate, 1'b1, "R10 gate held, early write ignored");
            chk(rx_flush, 1'b0, "R9 no flush on entry");
            chk(rx_held, r != 0, "R9 held flag");
            chk(phy_downshift_req, ds, "R6 downshift held");
        end
        pm_wr_en = 1'b1; pm_wr_code = 2'b11; step(); pm_wr_en = 1'b0;
        chk(in_low_power, 1'b1, "R11 repeated deep write ignored");
        chk(link_l1_req, 1'b1, "R11 link request kept");
        chk(rx_flush, 1'b0, "R11 no flush");
        pm_wr_en = 1'b1; pm_wr_code = 2'b00; step(); pm_wr_en = 1'b0;
        chk(rx_flush, r != 0, "R8 flush on exit");
        chk(sched_gate, 1'b0, "R8 gate released");
        chk(link_l1_req, 1'b0, "R8 link request dropped");
        chk(phy_downshift_req, 1'b0, "R6 downshift cleared");
        chk(in_low_power, 1'b0, "R8 left low power");
        link_l1_ack = 1'b0;
        step();
        chk(rx_flush, 1'b0, "R8 flush single cycle");
        chk(rx_held, 1'b0, "R9 held flag cleared");
        chk(sched_gate, 1'b0, "R8 back at full power");
        wake_en = 1'b0; pme_en = 1'b0;
    endtask

    initial begin
        step(); step();
        chk(sched_gate, 1'b0, "R1 reset gate");
        chk(mem_en_clr, 1'b0, "R1 reset mem clear");
        chk(io_en_clr, 1'b0, "R1 reset io clear");
        chk(link_l1_req, 1'b0, "R1 reset link request");
        chk(phy_downshift_req, 1'b0, "R1 reset downshift");
        chk(rx_flush, 1'b0, "R1 reset flush");
        chk(rx_held, 1'b0, "R1 reset held");
        chk(in_low_power, 1'b0, "R1 reset low power");
        rst_n = 1'b1;
        step();
        for (int n = 0; n < 8; n++)
            for (int w = 0; w < 4; w++)
                for (int r = 0; r < 2; r++)
                    run(n, w, r);
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        #(5 * 200000);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule